// File: doc/BRIEF.md
# Burst ROM Wait-State Controller

This block runs clock-synchronous burst reads from an external ROM for a single chip-select area. An internal requester raises `req` with a start address. The controller then drives the ROM chip select, read strobe and address and counts out programmed wait cycles before it samples each data beat. A burst has a fixed number of beats. The address steps by one data word (4 bytes for a 32-bit bus) per beat, and chip select stays low for the whole burst.

Two wait counts are held in a 32-bit control word. The first applies before the opening beat of a burst and the second before each later beat. An active-low external wait input can stretch any beat by one cycle per sample. A mask bit makes the controller ignore that input, and the mask applies even when the programmed wait count is zero. Each beat is returned with a one-cycle valid pulse, and a one-cycle done pulse follows the last beat.

Top module: `brom_seq`

## Requirements
- R1: The control word holds the later-beat wait count at bits 17:16, the first-beat wait count at bits 10:7 and the wait-mask bit at bit 6. A write with `cfg_we` high updates these fields, and `cfg_rdata` shows them.
- R2: Every other bit of `cfg_rdata` reads 0, and writing 1s to those bits changes nothing.
- R3: After reset the control word reads 0x0000_0500 (later-beat count 0, first-beat count 10, mask 0). `rom_cs_n` and `rom_rd_n` are high, and `beat_valid` and `done` are low.
- R4: With no external wait, the first beat is captured on the clock edge that comes first-beat-count + 1 edges after the edge that accepts `req`. The count may be 0 to 15.
- R5: With no external wait, each later beat is captured later-beat-count + 1 edges after the previous capture. The count codes 0 to 3 give 0 to 3 wait cycles.
- R6: When the mask is 0 and `rom_wait_n` is low on the edge where a capture is due, that capture is held back by one edge and the input is sampled again. This applies to any beat, including when the wait count is 0.
- R7: When the mask is 1, `rom_wait_n` has no effect on capture timing, including when the wait count is 0.
- R8: A burst has 4 beats at addresses base, base+4, base+8 and base+12, wrapping at the address width. Each `beat_data` equals `rom_data` at the capture edge. `rom_cs_n` and `rom_rd_n` are low from the cycle after acceptance up to the last capture edge.
- R9: `beat_valid` is high for one cycle after each capture edge. `done` is high for one cycle, one cycle after the last `beat_valid`, and `rom_cs_n` is high while `done` is high.
- R10: The control word is copied at the edge that accepts `req`. A write that lands during a burst changes only the timing of the next burst.
- R11: A `req` raised while a burst is in progress is ignored. It does not add beats and does not restart the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word read value |
| req | input | 1 | Burst read request, taken when idle |
| req_addr | input | AW | Burst start address (bytes) |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_addr | output | AW | ROM address of the current beat |
| rom_data | input | DW | ROM read data |
| rom_wait_n | input | 1 | External wait, active low |
| beat_valid | output | 1 | One-cycle pulse per captured beat |
| beat_data | output | DW | Captured beat data |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench builds the block with AW=16, DW=32 and the default 4 beats. The 16-bit address space lets a burst start at 0xFFF8 and wrap through zero, so address rollover is tested directly. The 32-bit data word lets the ROM model return a value that encodes its own address, so a wrong beat address shows up as wrong data. The default beat count keeps every burst under 60 cycles, which leaves room to sweep both wait counts, stall windows and the masked case with a wait count of zero.

// File: rtl/brom_pkg.sv
package brom_pkg;

    localparam int CNT_W    = 4;
    localparam int BW_LSB   = 16;
    localparam int AW_LSB   = 7;
    localparam int WM_BIT   = 6;

    typedef struct packed {
        logic [1:0]       bw;
        logic [CNT_W-1:0] aw;
        logic             wm;
    } brom_cfg_t;

    localparam brom_cfg_t CFG_RST = '{bw: 2'b00, aw: 4'b1010, wm: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_FIN  = 2'd2
    } brom_st_e;

endpackage

// File: rtl/brom_cfg_reg.sv
module brom_cfg_reg
    import brom_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output brom_cfg_t   cfg
);

    brom_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.bw = wdata[BW_LSB +: 2];
            cfg_d.aw = wdata[AW_LSB +: CNT_W];
            cfg_d.wm = wdata[WM_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                   = '0;
        rdata[BW_LSB +: 2]      = cfg_q.bw;
        rdata[AW_LSB +: CNT_W]  = cfg_q.aw;
        rdata[WM_BIT]           = cfg_q.wm;
    end

    assign cfg = cfg_q;

    // R1: a write is visible on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q.aw == $past(wdata[AW_LSB +: CNT_W])) && (cfg_q.wm == $past(wdata[WM_BIT])));

endmodule

// File: rtl/brom_wait_ctr.sv
module brom_wait_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R4/R5: one wait cycle is consumed per edge
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: an expired count stays expired until reloaded
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/brom_seq.sv
module brom_seq
    import brom_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    output logic          rom_cs_n,
    output logic          rom_rd_n,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    input  logic          rom_wait_n,
    output logic          beat_valid,
    output logic [DW-1:0] beat_data,
    output logic          done
);

    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int STEP   = DW / 8;
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    typedef struct packed {
        brom_st_e          st;
        logic [BEAT_W-1:0] beat;
        logic [AW-1:0]     base;
        brom_cfg_t         snap;
        logic              vld;
        logic [DW-1:0]     data;
        logic              done;
    } seq_t;

    seq_t             seq_d, seq_q;
    brom_cfg_t        cfg_cur;
    logic             ctr_load;
    logic [CNT_W-1:0] ctr_val;
    logic             ctr_zero;
    logic             capture;

    brom_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_cur)
    );

    brom_wait_ctr #(.CW(CNT_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .zero     (ctr_zero)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.vld  = 1'b0;
        seq_d.done = 1'b0;
        ctr_load   = 1'b0;
        ctr_val    = '0;
        capture    = (seq_q.st == ST_ACC) && ctr_zero && (rom_wait_n || seq_q.snap.wm);
        case (seq_q.st)
            ST_IDLE: begin
                if (req) begin
                    seq_d.st   = ST_ACC;
                    seq_d.base = req_addr;
                    seq_d.beat = '0;
                    seq_d.snap = cfg_cur;
                    ctr_load   = 1'b1;
                    ctr_val    = cfg_cur.aw;
                end
            end
            ST_ACC: begin
                if (capture) begin
                    seq_d.vld  = 1'b1;
                    seq_d.data = rom_data;
                    ctr_load   = 1'b1;
                    ctr_val    = CNT_W'(seq_q.snap.bw);
                    if (seq_q.beat == LAST) seq_d.st   = ST_FIN;
                    else                    seq_d.beat = seq_q.beat + 1'b1;
                end
            end
            ST_FIN: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.snap <= CFG_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rom_cs_n   = (seq_q.st != ST_ACC);
    assign rom_rd_n   = (seq_q.st != ST_ACC);
    assign rom_addr   = seq_q.base + AW'(seq_q.beat) * AW'(STEP);
    assign beat_valid = seq_q.vld;
    assign beat_data  = seq_q.data;
    assign done       = seq_q.done;

    // R9: done comes one cycle after a beat and with the ROM deselected
    a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(beat_valid) && rom_cs_n));

    // R8: every beat was sampled while the ROM was selected
    a_r8_cs_before_beat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !$past(rom_cs_n));

    // R10: the copied control word cannot change mid-burst
    a_r10_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st != ST_IDLE) && $past(seq_q.st != ST_IDLE)) |-> $stable(seq_q.snap));

    // R6: an unmasked low wait input holds the beat back
    a_r6_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_ACC) && ctr_zero && !seq_q.snap.wm && !rom_wait_n)
            |=> (!beat_valid && seq_q.st == ST_ACC));

    // R7: with the mask set, a due beat is always captured
    a_r7_mask_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_ACC) && ctr_zero && seq_q.snap.wm) |=> beat_valid);

endmodule

// File: tb/test_brom_seq.sv
`timescale 1ns/1ps
module test_brom_seq;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rom_cs_n, rom_rd_n;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic          rom_wait_n = 1'b1;
    logic          beat_valid;
    logic [DW-1:0] beat_data;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    assign rom_data = {~rom_addr, rom_addr};

    brom_seq #(.AW(AW), .DW(DW), .BEATS(4)) i_brom_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_addr(req_addr),
        .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_addr(rom_addr),
        .rom_data(rom_data), .rom_wait_n(rom_wait_n), .beat_valid(beat_valid),
        .beat_data(beat_data), .done(done)
    );

    function automatic logic [31:0] rom_fn(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int bw, input int aw, input int wm);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = (32'(bw) << 16) | (32'(aw) << 7) | (32'(wm) << 6);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Runs one burst; stall window [wlo,whi] counts edges after acceptance.
    task automatic burst(input string rq, input logic [AW-1:0] base,
                         input int aw, input int bw, input int wm,
                         input int wlo, input int whi,
                         input bit poke_cfg, input logic [31:0] poke_val,
                         input bit poke_req);
        int exp_t[4];
        int act_t[4];
        logic [31:0] act_d[4];
        int nv = 0;
        int done_at = -1;
        int done_cnt = 0;
        bit cs_bad = 1'b0;
        int e;
        int last;
        e = aw + 1;
        for (int j = 0; j < 4; j++) begin
            if (j > 0) e = exp_t[j-1] + bw + 1;
            while (wm == 0 && e >= wlo && e <= whi) e++;
            exp_t[j] = e;
            act_t[j] = -1;
            act_d[j] = '0;
        end
        last = exp_t[3];
        @(negedge clk);
        req        = 1'b1;
        req_addr   = base;
        rom_wait_n = 1'b1;
        for (int n = 0; n <= last + 4; n++) begin
            @(negedge clk);
            req = 1'b0;
            if (beat_valid) begin
                if (nv < 4) begin
                    act_t[nv] = n;
                    act_d[nv] = beat_data;
                end
                nv++;
            end
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = n;
            end
            if (rom_cs_n != (n >= last) || rom_rd_n != rom_cs_n) cs_bad = 1'b1;
            rom_wait_n = !((n + 1) >= wlo && (n + 1) <= whi);
            cfg_we = 1'b0;
            if (poke_cfg && n == 2) begin
                cfg_we    = 1'b1;
                cfg_wdata = poke_val;
            end
            if (poke_req && n == 3) begin
                req      = 1'b1;
                req_addr = base ^ 16'h0800;
            end
        end
        req = 1'b0;
        rom_wait_n = 1'b1;
        for (int j = 0; j < 4; j++) begin
            chk(act_t[j] == exp_t[j], rq, $sformatf("beat %0d capture cycle", j),
                32'(act_t[j]), 32'(exp_t[j]));
            chk(act_d[j] == rom_fn(base + AW'(4 * j)), "R8",
                $sformatf("%s beat %0d data", rq, j), act_d[j], rom_fn(base + AW'(4 * j)));
        end
        chk(nv == 4, "R11", $sformatf("%s beat count", rq), 32'(nv), 32'd4);
        chk(done_at == last + 1 && done_cnt == 1, "R9", $sformatf("%s done cycle", rq),
            32'(done_at), 32'(last + 1));
        chk(!cs_bad, "R8", $sformatf("%s cs/rd window", rq), 32'(cs_bad), 32'd0);
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 32'h0000_0500, "R3", "reset control word", cfg_rdata, 32'h0000_0500);
        chk(rom_cs_n && rom_rd_n, "R3", "reset strobes", {30'd0, rom_cs_n, rom_rd_n}, 32'd3);
        chk(!beat_valid && !done, "R3", "reset pulses", {30'd0, beat_valid, done}, 32'd0);
    endtask

    task automatic t_default;
        burst("R4", 16'h0040, 10, 0, 0, 0, -1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_regs;
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); cfg_we = 1'b0;
        chk(cfg_rdata == 32'h0003_07C0, "R2", "all-ones write", cfg_rdata, 32'h0003_07C0);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'hF002_8201;
        @(negedge clk); cfg_we = 1'b0;
        chk(cfg_rdata == 32'h0002_0200, "R1", "field write", cfg_rdata, 32'h0002_0200);
    endtask

    task automatic t_timing;
        set_cfg(3, 2, 0);
        burst("R5", 16'h0100, 2, 3, 0, 0, -1, 1'b0, '0, 1'b0);
        set_cfg(1, 15, 0);
        burst("R4", 16'h2000, 15, 1, 0, 0, -1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_stall;
        set_cfg(1, 1, 0);
        burst("R6", 16'h0300, 1, 1, 0, 4, 6, 1'b0, '0, 1'b0);
        set_cfg(1, 1, 1);
        burst("R7", 16'h0300, 1, 1, 1, 4, 6, 1'b0, '0, 1'b0);
    endtask

    task automatic t_zero;
        set_cfg(0, 0, 0);
        burst("R6", 16'h0500, 0, 0, 0, 1, 3, 1'b0, '0, 1'b0);
        set_cfg(0, 0, 1);
        burst("R7", 16'h0500, 0, 0, 1, 1, 3, 1'b0, '0, 1'b0);
    endtask

    task automatic t_wrap;
        set_cfg(2, 1, 0);
        burst("R8", 16'hFFF8, 1, 2, 0, 0, -1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_cfg_mid;
        set_cfg(0, 3, 0);
        burst("R10", 16'h0700, 3, 0, 0, 0, -1, 1'b1, 32'h0002_0300, 1'b0);
        burst("R10", 16'h0700, 6, 2, 0, 0, -1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_busy_req;
        set_cfg(1, 4, 0);
        burst("R11", 16'h0900, 4, 1, 0, 0, -1, 1'b0, '0, 1'b1);
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_regs();
        t_timing();
        t_stall();
        t_zero();
        t_wrap();
        t_cfg_mid();
        t_busy_req();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule